// File: doc/BRIEF.md
# Receive Data-Phase Framing Tracker

This block sits on the application side of a receive path in which every packet is first announced by a request strobe carrying a descriptor word and a one-hot address-region field, and is then optionally followed by a data phase. The tracker turns that two-phase protocol into a flat stream of 64-bit records. Each record carries start and last markers and a 3-bit region tag. The stream is held in a 16-entry buffer that the consumer drains with a ready signal.

The end of a payload is never computed from a length. A framing input rises during the request cycle or some cycle after it, and it falls one cycle ahead of the final data beat. The first valid beat that follows a cycle in which framing was seen low is therefore the last beat of the packet. A request whose descriptor says it has no payload becomes a single header record at once.

While the buffer is close to full, the block raises a retry output and a non-posted mask output together. This asks the upstream side to stop sending non-posted requests. Both outputs are released with hysteresis once the buffer has drained.

Top module: `rx_frame_tracker`

## Requirements
- R1: The region tag is the index of the single set bit among region bits 0..6. Bits 0..5 select windows 0..5, and bit 6 (the expansion ROM window) gives tag 6. Any other region value gives tag 7.
- R2: A request accepted with region bits 0..6 not exactly one-hot, or with bit 7 set, sets err_o one cycle later. err_o then stays high until reset.
- R3: A request accepted while idle with descriptor bit 62 low writes one record with start=1, last=1, hdr=1 and data equal to the descriptor. The record appears on the output one cycle later.
- R4: With descriptor bit 62 high, framing may be high in the request cycle or rise later. Valid beats seen before framing has been high are ignored.
- R5: During a data phase, every cycle with valid_i high writes data_i as one record with hdr=0, and cycles with valid_i low write nothing. A record appears on the output one cycle after its beat, in arrival order. The first record of a packet has start=1.
- R6: Once framing has been sampled low during a data phase, the next valid beat is written with last=1. The tracker then returns to idle. Earlier beats have last=0.
- R7: All records of one packet carry the region tag latched at its request. Request strobes that arrive during a data phase are ignored.
- R8: retry_o and mask_o rise together one cycle after the buffer holds 14 or more entries. They stay high while the fill is 9 to 13 and fall together one cycle after it is 8 or fewer.
- R9: The buffer holds up to 16 records. out_valid_o is high while it is non-empty, and a record is removed when out_valid_o and out_ready_i are both high. A record offered while the buffer is full and not popping is dropped.
- R10: A synchronous active-high reset empties the buffer, clears err_o, retry_o and mask_o, and abandons any partly received packet, so that a later valid beat without a new request writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe, descriptor phase |
| desc_i | input | 64 | Descriptor word; bit 62 marks a payload |
| region_i | input | 8 | One-hot address-region decode |
| frame_i | input | 1 | Data-phase framing |
| valid_i | input | 1 | Data beat valid |
| data_i | input | 64 | Data beat |
| out_ready_i | input | 1 | Consumer accepts the head record |
| out_valid_o | output | 1 | Head record present |
| out_data_o | output | 64 | Record data |
| out_start_o | output | 1 | First record of a packet |
| out_last_o | output | 1 | Final record of a packet |
| out_hdr_o | output | 1 | Descriptor-only record |
| out_region_o | output | 3 | Region tag |
| retry_o | output | 1 | Retry request to upstream |
| mask_o | output | 1 | Non-posted request mask |
| err_o | output | 1 | Sticky region-decode error |

## Verification
The two functions that can coincide are the end-of-packet detection and a fresh request strobe. A request can arrive in the same cycle as a valid beat while a packet is still being framed. The bench drives such a request alongside the first beat of a payload. It then judges that the beat is emitted with the old packet's region tag, that no header record for the stray request ever appears, and that the final beat still gets its last marker. A second pairing comes from the buffer side: draining and the release of retry and mask interact across the hysteresis band, and the bench checks that release waits for a fill of 8 after pops and idle cycles are interleaved.

// File: rtl/rx_ft_pkg.sv
package rx_ft_pkg;

    localparam int WORD_W   = 64;
    localparam int REGION_W = 8;
    localparam int WIN_N    = 7;
    localparam int TAG_W    = 3;
    localparam logic [TAG_W-1:0] TAG_BAD = 3'd7;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_WAIT = 2'd1,
        TRK_DATA = 2'd2,
        TRK_TAIL = 2'd3
    } trk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic              start;
        logic              last;
        logic              hdr;
    } beat_t;

endpackage

// File: rtl/rx_region_decode.sv
module rx_region_decode
    import rx_ft_pkg::*;
(
    input  logic [REGION_W-1:0] region_i,
    output logic [TAG_W-1:0]    tag_o,
    output logic                bad_o
);

    logic [TAG_W-1:0] idx;
    logic [TAG_W:0]   ones;

    always_comb begin
        idx  = '0;
        ones = '0;
        for (int i = 0; i < WIN_N; i++) begin
            if (region_i[i]) begin
                idx  = TAG_W'(i);
                ones = ones + 1'b1;
            end
        end
    end

    // reserved top bit or a non-one-hot window field marks the request bad
    assign bad_o = (ones != 1) || region_i[REGION_W-1];
    assign tag_o = bad_o ? TAG_BAD : idx;

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_ft_pkg::*;
#(
    parameter int PAYLOAD_BIT = 62
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [WORD_W-1:0] desc_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              bad_i,
    input  logic              frame_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              wr_o,
    output beat_t             wr_beat_o,
    output logic              err_o
);

    typedef struct packed {
        trk_state_e       st;
        logic [TAG_W-1:0] tag;
        logic             first;
        logic             err;
    } fsm_s;

    fsm_s  trk_d, trk_q;
    logic  wr_d;
    beat_t beat_d;

    always_comb begin
        trk_d  = trk_q;
        wr_d   = 1'b0;
        beat_d = '0;
        unique case (trk_q.st)
            TRK_IDLE: begin
                if (req_i) begin
                    trk_d.err = trk_q.err | bad_i;
                    trk_d.tag = tag_i;
                    if (!desc_i[PAYLOAD_BIT]) begin
                        wr_d         = 1'b1;
                        beat_d.data  = desc_i;
                        beat_d.tag   = tag_i;
                        beat_d.start = 1'b1;
                        beat_d.last  = 1'b1;
                        beat_d.hdr   = 1'b1;
                    end else begin
                        trk_d.first = 1'b1;
                        trk_d.st    = frame_i ? TRK_DATA : TRK_WAIT;
                    end
                end
            end
            TRK_WAIT: begin
                if (frame_i) begin
                    trk_d.st = TRK_DATA;
                end
            end
            TRK_DATA: begin
                if (valid_i) begin
                    wr_d         = 1'b1;
                    beat_d.data  = data_i;
                    beat_d.tag   = trk_q.tag;
                    beat_d.start = trk_q.first;
                    trk_d.first  = 1'b0;
                end
                if (!frame_i) begin
                    trk_d.st = TRK_TAIL;
                end
            end
            TRK_TAIL: begin
                if (valid_i) begin
                    wr_d         = 1'b1;
                    beat_d.data  = data_i;
                    beat_d.tag   = trk_q.tag;
                    beat_d.start = trk_q.first;
                    beat_d.last  = 1'b1;
                    trk_d.first  = 1'b0;
                    trk_d.st     = TRK_IDLE;
                end
            end
            default: trk_d.st = TRK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '{st: TRK_IDLE, tag: '0, first: 1'b0, err: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign wr_o      = wr_d;
    assign wr_beat_o = beat_d;
    assign err_o     = trk_q.err;

endmodule

// File: rtl/rx_beat_fifo.sv
module rx_beat_fifo
    import rx_ft_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  beat_t            push_beat_i,
    input  logic             pop_i,
    output beat_t            head_o,
    output logic             nonempty_o,
    output logic [CNT_W-1:0] fill_o
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } fifo_s;

    fifo_s fifo_d, fifo_q;
    beat_t mem [DEPTH];
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fifo_d  = fifo_q;
        do_pop  = pop_i && (fifo_q.cnt != '0);
        do_push = push_i && ((fifo_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (do_push) fifo_d.wr = bump(fifo_q.wr);
        if (do_pop)  fifo_d.rd = bump(fifo_q.rd);
        case ({do_push, do_pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[fifo_q.wr] <= push_beat_i;
        end
    end

    assign head_o     = mem[fifo_q.rd];
    assign nonempty_o = (fifo_q.cnt != '0);
    assign fill_o     = fifo_q.cnt;

endmodule

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl #(
    parameter int CNT_W   = 5,
    parameter int HI_MARK = 14,
    parameter int LO_MARK = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fill_i,
    output logic             retry_o,
    output logic             mask_o
);

    typedef struct packed {
        logic retry;
        logic mask;
    } hold_s;

    hold_s hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (fill_i >= CNT_W'(HI_MARK)) begin
            hold_d.retry = 1'b1;
            hold_d.mask  = 1'b1;
        end else if (fill_i <= CNT_W'(LO_MARK)) begin
            hold_d.retry = 1'b0;
            hold_d.mask  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign retry_o = hold_q.retry;
    assign mask_o  = hold_q.mask;

endmodule

// File: rtl/rx_frame_tracker.sv
module rx_frame_tracker
    import rx_ft_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int HI_MARK     = 14,
    parameter int LO_MARK     = 8,
    parameter int PAYLOAD_BIT = 62,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  logic [WORD_W-1:0]   desc_i,
    input  logic [REGION_W-1:0] region_i,
    input  logic                frame_i,
    input  logic                valid_i,
    input  logic [WORD_W-1:0]   data_i,
    input  logic                out_ready_i,
    output logic                out_valid_o,
    output logic [WORD_W-1:0]   out_data_o,
    output logic                out_start_o,
    output logic                out_last_o,
    output logic                out_hdr_o,
    output logic [TAG_W-1:0]    out_region_o,
    output logic                retry_o,
    output logic                mask_o,
    output logic                err_o
);

    logic [TAG_W-1:0] req_tag;
    logic             req_bad;
    logic             wr_en;
    beat_t            wr_beat;
    beat_t            head;
    logic [CNT_W-1:0] fill_cnt;

    rx_region_decode u_dec (
        .region_i (region_i),
        .tag_o    (req_tag),
        .bad_o    (req_bad)
    );

    rx_frame_fsm #(
        .PAYLOAD_BIT (PAYLOAD_BIT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .desc_i    (desc_i),
        .tag_i     (req_tag),
        .bad_i     (req_bad),
        .frame_i   (frame_i),
        .valid_i   (valid_i),
        .data_i    (data_i),
        .wr_o      (wr_en),
        .wr_beat_o (wr_beat),
        .err_o     (err_o)
    );

    rx_beat_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .push_i      (wr_en),
        .push_beat_i (wr_beat),
        .pop_i       (out_ready_i),
        .head_o      (head),
        .nonempty_o  (out_valid_o),
        .fill_o      (fill_cnt)
    );

    rx_hold_ctrl #(
        .CNT_W   (CNT_W),
        .HI_MARK (HI_MARK),
        .LO_MARK (LO_MARK)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .fill_i  (fill_cnt),
        .retry_o (retry_o),
        .mask_o  (mask_o)
    );

    assign out_data_o   = head.data;
    assign out_start_o  = head.start;
    assign out_last_o   = head.last;
    assign out_hdr_o    = head.hdr;
    assign out_region_o = head.tag;

endmodule

// File: rtl/rx_frame_tracker_chk.sv
module rx_frame_tracker_chk #(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 14,
    parameter int LO_MARK = 8,
    parameter int CNT_W   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] fill_cnt,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [63:0]      out_data_o,
    input logic             out_start_o,
    input logic             out_last_o,
    input logic             out_hdr_o,
    input logic [2:0]       out_region_o,
    input logic             retry_o,
    input logic             mask_o,
    input logic             err_o
);

    logic       in_pkt_q;
    logic [2:0] pkt_tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt_q  <= 1'b0;
            pkt_tag_q <= '0;
        end else if (out_valid_o && out_ready_i) begin
            if (out_last_o) begin
                in_pkt_q <= 1'b0;
            end else if (out_start_o) begin
                in_pkt_q  <= 1'b1;
                pkt_tag_q <= out_region_o;
            end
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(DEPTH));

    a_r9_head_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    a_r8_hold_rise: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt >= CNT_W'(HI_MARK)) |=> (retry_o && mask_o));

    a_r8_hold_fall: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt <= CNT_W'(LO_MARK)) |=> (!retry_o && !mask_o));

    a_r8_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(retry_o) |-> mask_o);

    a_r2_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    a_r3_hdr_single: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_hdr_o) |-> (out_start_o && out_last_o));

    a_r7_tag_steady: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && in_pkt_q) |-> (out_region_o == pkt_tag_q && !out_start_o));

endmodule

bind rx_frame_tracker rx_frame_tracker_chk #(
    .DEPTH   (DEPTH),
    .HI_MARK (HI_MARK),
    .LO_MARK (LO_MARK),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fill_cnt     (fill_cnt),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o),
    .out_start_o  (out_start_o),
    .out_last_o   (out_last_o),
    .out_hdr_o    (out_hdr_o),
    .out_region_o (out_region_o),
    .retry_o      (retry_o),
    .mask_o       (mask_o),
    .err_o        (err_o)
);

// File: tb/rx_frame_tracker_bench.sv
`timescale 1ns/1ps
module rx_frame_tracker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [63:0] desc_i = '0;
    logic [7:0]  region_i = '0;
    logic        frame_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] data_i = '0;
    logic        out_ready_i = 1'b1;
    logic        out_valid_o;
    logic [63:0] out_data_o;
    logic        out_start_o;
    logic        out_last_o;
    logic        out_hdr_o;
    logic [2:0]  out_region_o;
    logic        retry_o;
    logic        mask_o;
    logic        err_o;

    int total = 0;
    int bad   = 0;

    localparam logic [55:0] DPAT = 56'hC0DE_0000_5A5A_77;

    always #2.5 clk = ~clk;

    rx_frame_tracker u_rx_frame_tracker (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_i),
        .desc_i       (desc_i),
        .region_i     (region_i),
        .frame_i      (frame_i),
        .valid_i      (valid_i),
        .data_i       (data_i),
        .out_ready_i  (out_ready_i),
        .out_valid_o  (out_valid_o),
        .out_data_o   (out_data_o),
        .out_start_o  (out_start_o),
        .out_last_o   (out_last_o),
        .out_hdr_o    (out_hdr_o),
        .out_region_o (out_region_o),
        .retry_o      (retry_o),
        .mask_o       (mask_o),
        .err_o        (err_o)
    );

    typedef struct packed {
        logic       req;
        logic       pl;
        logic [7:0] rg;
        logic       frm;
        logic       vld;
        logic [7:0] b;
        logic       ev;
        logic       es;
        logic       el;
        logic       eh;
        logic [2:0] etag;
        logic [7:0] eb;
        logic       eerr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,8'h01,1'b0,1'b0,8'h10, 1'b1,1'b1,1'b1,1'b1,3'd0,8'h10,1'b0},
        '{1'b1,1'b1,8'h04,1'b1,1'b0,8'h11, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b0,1'b0,8'h00,1'b1,1'b1,8'h21, 1'b1,1'b1,1'b0,1'b0,3'd2,8'h21,1'b0},
        '{1'b0,1'b0,8'h00,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h22, 1'b1,1'b0,1'b0,1'b0,3'd2,8'h22,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h23, 1'b1,1'b0,1'b1,1'b0,3'd2,8'h23,1'b0},
        '{1'b1,1'b1,8'h40,1'b0,1'b0,8'h13, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h30, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b0,1'b0,8'h00,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h31, 1'b1,1'b1,1'b1,1'b0,3'd6,8'h31,1'b0},
        '{1'b1,1'b0,8'h08,1'b0,1'b0,8'h12, 1'b1,1'b1,1'b1,1'b1,3'd3,8'h12,1'b0},
        '{1'b1,1'b1,8'h20,1'b1,1'b0,8'h14, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0},
        '{1'b1,1'b0,8'h01,1'b1,1'b1,8'h41, 1'b1,1'b1,1'b0,1'b0,3'd5,8'h41,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h42, 1'b1,1'b0,1'b0,1'b0,3'd5,8'h42,1'b0},
        '{1'b0,1'b0,8'h00,1'b0,1'b1,8'h43, 1'b1,1'b0,1'b1,1'b0,3'd5,8'h43,1'b0},
        '{1'b1,1'b0,8'h03,1'b0,1'b0,8'h17, 1'b1,1'b1,1'b1,1'b1,3'd7,8'h17,1'b1}
    };

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic step(input logic rq, input logic pl, input logic [7:0] rg,
                        input logic frm, input logic vld, input logic [7:0] b);
        req_i    = rq;
        desc_i   = {1'b0, pl, 54'h0, b};
        region_i = rg;
        frame_i  = frm;
        valid_i  = vld;
        data_i   = {DPAT, b};
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    endtask

    int popped = 0;
    logic [7:0] first_b = '0;
    logic [7:0] last_b  = '0;

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) begin
            out_ready_i = 1'b1;
            if (out_valid_o) begin
                if (popped == 0) first_b = out_data_o[7:0];
                last_b = out_data_o[7:0];
                popped++;
            end
            idle();
        end
        out_ready_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10: state held in reset
        check("R10 reset out_valid", 64'(out_valid_o), 64'd0);
        check("R10 reset retry", 64'(retry_o), 64'd0);
        check("R10 reset mask", 64'(mask_o), 64'd0);
        check("R10 reset err", 64'(err_o), 64'd0);
        rst = 1'b0;

        // table walk: R1 R3 R4 R5 R6 R7 R2
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].req, VEC[i].pl, VEC[i].rg, VEC[i].frm, VEC[i].vld, VEC[i].b);
            check($sformatf("R4 R5 row%0d out_valid", i), 64'(out_valid_o), 64'(VEC[i].ev));
            if (VEC[i].ev) begin
                check($sformatf("R5 row%0d start", i), 64'(out_start_o), 64'(VEC[i].es));
                check($sformatf("R6 row%0d last", i), 64'(out_last_o), 64'(VEC[i].el));
                check($sformatf("R3 row%0d hdr", i), 64'(out_hdr_o), 64'(VEC[i].eh));
                check($sformatf("R1 R7 row%0d tag", i), 64'(out_region_o), 64'(VEC[i].etag));
                check($sformatf("R5 row%0d data", i), out_data_o,
                      VEC[i].eh ? {2'b00, 54'h0, VEC[i].eb} : {DPAT, VEC[i].eb});
            end
            check($sformatf("R2 row%0d err", i), 64'(err_o), 64'(VEC[i].eerr));
        end
        idle();
        check("R2 err sticky", 64'(err_o), 64'd1);

        // R10: reset clears sticky error
        rst = 1'b1;
        idle();
        rst = 1'b0;
        check("R10 err cleared", 64'(err_o), 64'd0);

        // R2 R1: reserved bit alone
        step(1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 8'h55);
        check("R2 reserved bit err", 64'(err_o), 64'd1);
        check("R1 reserved bit tag", 64'(out_region_o), 64'd7);
        idle();

        // R10: reset in the middle of a packet
        rst = 1'b1;
        idle();
        rst = 1'b0;
        step(1'b1, 1'b1, 8'h02, 1'b1, 1'b0, 8'h60);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h61);
        check("R5 mid-packet beat", 64'(out_valid_o), 64'd1);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h62);
        check("R10 abandoned packet writes nothing", 64'(out_valid_o), 64'd0);
        idle();
        check("R10 still empty", 64'(out_valid_o), 64'd0);

        // R8 R9: fill with ready low
        out_ready_i = 1'b0;
        for (int k = 0; k < 13; k++) step(1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 8'(k));
        idle();
        idle();
        check("R8 retry low at 13", 64'(retry_o), 64'd0);
        step(1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 8'd13);
        check("R8 retry lags fill", 64'(retry_o), 64'd0);
        idle();
        check("R8 retry high at 14", 64'(retry_o), 64'd1);
        check("R8 mask high at 14", 64'(mask_o), 64'd1);
        for (int k = 14; k < 18; k++) step(1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 8'(k));
        drain(7);
        idle();
        check("R8 retry held at 9", 64'(retry_o), 64'd1);
        drain(1);
        idle();
        check("R8 retry released at 8", 64'(retry_o), 64'd0);
        check("R8 mask released at 8", 64'(mask_o), 64'd0);
        drain(10);
        check("R9 records kept", 64'(popped), 64'd16);
        check("R9 first kept", 64'(first_b), 64'd0);
        check("R9 last kept", 64'(last_b), 64'd15);
        check("R9 empty after drain", 64'(out_valid_o), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule